// File: doc/BRIEF.md
# Pipelined SRAM Deselect and Sleep Control

This block is the command and read-data path of a pipelined synchronous SRAM model. Each clock edge captures one command into an input stage: deselect, read or write. A read presents its word and raises the data-drive enable one edge later. A write stores the captured data into a lane-organised array. Writes can target single byte lanes or the whole word.

A static mode input picks how fast the output drivers switch off once a non-read command follows a read. In single-cycle mode the drivers drop as soon as that command sits in the input stage, so the last read of a run is never driven. In dual-cycle mode the drivers follow the read pipeline, so every read gets its full output cycle. An asynchronous output enable gates the drive enable on top of the pipeline.

A sleep request is synchronised into the clock domain. While the block sleeps it ignores all commands, keeps the memory contents and holds the drivers off. After the request is released, a recovery window of a parameterised number of cycles follows. In that window reads are served and writes are dropped, and each dropped write raises an error flag.

Top module: `sram_pipe_ctrl`

## Requirements
- R1: A read with `cen`=1 and `wr`=0 that is captured at edge k shows the addressed word on `rdata` after edge k+1. In that same cycle `rdata_drv` is high, given that `oe` is high and the drivers are not switched off by R2 or R6.
- R2: With `desel_single`=1, `rdata_drv` is low whenever the command captured at the latest edge is not a read (a deselect or a write). This holds even in the cycle that follows a read.
- R3: With `desel_single`=0, a read captured at edge k keeps `rdata_drv` high after edge k+1, whatever command edge k+1 captures. If edge k+1 captured a deselect, `rdata_drv` is low after edge k+2.
- R4: Take a write with `gw`=0 and `bw_en`=1. It updates exactly the lanes i whose `lane_sel[i]` is 1, where lane i is bits [8i+7:8i] of the word. A write with `gw`=0 and `bw_en`=0 changes no lane.
- R5: A write with `gw`=1 updates all lanes, whatever the values of `bw_en` and `lane_sel`.
- R6: Once `sleep_req` has been high at two consecutive edges, the block is asleep. From then on `rdata_drv` is low. Commands captured while asleep have no effect, writes included, and they raise no error.
- R7: The memory contents written before sleep can be read back unchanged after wake.
- R8: `sleep_req` must be seen low at two edges before the block wakes. After wake there are RECOVER_CYCLES edges at which a captured write is dropped and `wr_drop_err` is high for the cycle after that edge. Reads at those edges are served. A write at the next edge is performed, with no error.
- R9: `oe`=0 forces `rdata_drv` low without a clock edge. Returning `oe` to 1 restores the drive, and the pipeline state is unchanged.
- R10: During reset, `rdata_drv` and `wr_drop_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cen | input | 1 | Chip enable; 0 captures a deselect |
| wr | input | 1 | 1 = write command, 0 = read command |
| addr | input | ADDR_W | Word address |
| bw_en | input | 1 | Byte-write enable |
| gw | input | 1 | Global write, all lanes |
| lane_sel | input | LANES | Per-lane select for byte writes |
| wdata | input | LANES*LANE_W | Write data |
| oe | input | 1 | Asynchronous output enable |
| desel_single | input | 1 | 1 = single-cycle deselect, 0 = dual-cycle deselect |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| rdata | output | LANES*LANE_W | Read data |
| rdata_drv | output | 1 | Read-data drive enable |
| wr_drop_err | output | 1 | Pulses when a write is dropped during recovery |

## Verification
The hardest situation to reach is the edge of the recovery window. The write in the last recovering cycle must be dropped, and the write one cycle later must land. Reaching that point means counting every edge from the release of the sleep request: two through the synchroniser, then the RECOVER_CYCLES window. The stimulus releases the request at a known falling edge and steps through idle cycles to the wake edge. It then places writes at window positions 1, RECOVER_CYCLES and RECOVER_CYCLES+1, and afterwards reads all three addresses back.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

endpackage

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl #(
    parameter int RECOVER_CYCLES = 4,
    localparam int CNT_W = $clog2(RECOVER_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic wr_attempt,
    output logic asleep,
    output logic recovering,
    output logic wr_drop_err
);

    typedef struct packed {
        logic             sync1;
        logic             sync2;
        logic [CNT_W-1:0] rec;
        logic             err;
    } state_t;

    state_t st_d, st_q;

    assign asleep      = st_q.sync2;
    assign recovering  = !st_q.sync2 && (st_q.rec != '0);
    assign wr_drop_err = st_q.err;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = sleep_req;
        st_d.sync2 = st_q.sync1;
        if (st_q.sync2) begin
            st_d.rec = CNT_W'(RECOVER_CYCLES);
        end else if (st_q.rec != '0) begin
            st_d.rec = st_q.rec - 1'b1;
        end
        st_d.err = recovering && wr_attempt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sram_cmd_stage.sv
module sram_cmd_stage
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bw_en,
    input  logic              gw,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              asleep,
    input  logic              recovering,
    output cmd_e              s1_cmd,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [DATA_W-1:0] s1_wdata,
    output logic [LANES-1:0]  s1_mask
);

    typedef struct packed {
        cmd_e              cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  mask;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.addr = addr;
        st_d.data = wdata;
        if (gw) begin
            st_d.mask = '1;
        end else if (bw_en) begin
            st_d.mask = lane_sel;
        end else begin
            st_d.mask = '0;
        end
        if (asleep || !cen) begin
            st_d.cmd = CMD_IDLE;
        end else if (wr) begin
            st_d.cmd = recovering ? CMD_IDLE : CMD_WRITE;
        end else begin
            st_d.cmd = CMD_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cmd: CMD_IDLE, addr: '0, data: '0, mask: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_cmd   = st_q.cmd;
    assign s1_addr  = st_q.addr;
    assign s1_wdata = st_q.data;
    assign s1_mask  = st_q.mask;

endmodule

// File: rtl/sram_lane_mem.sv
module sram_lane_mem #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  mask,
    output logic [DATA_W-1:0] rdata
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we && mask[i]) begin
                bank[addr] <= wdata[i*LANE_W +: LANE_W];
            end
        end

        assign rdata[i*LANE_W +: LANE_W] = bank[addr];
    end

endmodule

// File: rtl/sram_drive_ctrl.sv
module sram_drive_ctrl
    import sram_pipe_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              s1_cmd,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              desel_single,
    input  logic              oe,
    input  logic              asleep,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drv
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              drv;
    } out_t;

    out_t st_d, st_q;
    logic hold_ok;

    always_comb begin
        st_d     = st_q;
        st_d.drv = (s1_cmd == CMD_READ);
        if (s1_cmd == CMD_READ) begin
            st_d.data = mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Single-cycle mode cuts the drive as soon as a non-read is captured.
    assign hold_ok   = desel_single ? (s1_cmd == CMD_READ) : 1'b1;
    assign rdata     = st_q.data;
    assign rdata_drv = st_q.drv && hold_ok && oe && !asleep;

endmodule

// File: rtl/sram_pipe_ctrl.sv
module sram_pipe_ctrl
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W         = 6,
    parameter int LANES          = 4,
    parameter int LANE_W         = 8,
    parameter int RECOVER_CYCLES = 4,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bw_en,
    input  logic              gw,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oe,
    input  logic              desel_single,
    input  logic              sleep_req,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drv,
    output logic              wr_drop_err
);

    logic              asleep;
    logic              recovering;
    cmd_e              s1_cmd;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] s1_wdata;
    logic [LANES-1:0]  s1_mask;
    logic [DATA_W-1:0] mem_rdata;

    sram_sleep_ctrl #(
        .RECOVER_CYCLES(RECOVER_CYCLES)
    ) u_sleep (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .wr_attempt (cen && wr),
        .asleep     (asleep),
        .recovering (recovering),
        .wr_drop_err(wr_drop_err)
    );

    sram_cmd_stage #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cen       (cen),
        .wr        (wr),
        .addr      (addr),
        .bw_en     (bw_en),
        .gw        (gw),
        .lane_sel  (lane_sel),
        .wdata     (wdata),
        .asleep    (asleep),
        .recovering(recovering),
        .s1_cmd    (s1_cmd),
        .s1_addr   (s1_addr),
        .s1_wdata  (s1_wdata),
        .s1_mask   (s1_mask)
    );

    sram_lane_mem #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_mem (
        .clk  (clk),
        .we   (s1_cmd == CMD_WRITE),
        .addr (s1_addr),
        .wdata(s1_wdata),
        .mask (s1_mask),
        .rdata(mem_rdata)
    );

    sram_drive_ctrl #(
        .DATA_W(DATA_W)
    ) u_drv (
        .clk         (clk),
        .rst_n       (rst_n),
        .s1_cmd      (s1_cmd),
        .mem_rdata   (mem_rdata),
        .desel_single(desel_single),
        .oe          (oe),
        .asleep      (asleep),
        .rdata       (rdata),
        .rdata_drv   (rdata_drv)
    );

    // A read in the input stage appears on rdata one edge later.
    assert_read_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_cmd == CMD_READ) |=> (rdata == $past(mem_rdata)));

    // While asleep, nothing reaches the input stage.
    assert_sleep_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> (s1_cmd == CMD_IDLE));

    // A write offered during recovery never becomes a write command.
    assert_no_write_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (recovering && cen && wr) |=> (s1_cmd != CMD_WRITE));

    // A write offered during recovery is reported.
    assert_drop_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (recovering && cen && wr) |=> wr_drop_err);

    // The error only follows a recovery cycle.
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop_err |-> $past(recovering));

endmodule

// File: tb/test_sram_pipe_ctrl.sv
module test_sram_pipe_ctrl;

    localparam int AW  = 6;
    localparam int LN  = 4;
    localparam int LW  = 8;
    localparam int DW  = LN * LW;
    localparam int REC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cen = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          bw_en = 1'b0;
    logic          gw = 1'b0;
    logic [LN-1:0] lane_sel = '0;
    logic [DW-1:0] wdata = '0;
    logic          oe = 1'b1;
    logic          desel_single = 1'b1;
    logic          sleep_req = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_drv;
    logic          wr_drop_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sram_pipe_ctrl #(
        .ADDR_W(AW), .LANES(LN), .LANE_W(LW), .RECOVER_CYCLES(REC)
    ) i_sram_pipe_ctrl (
        .clk(clk), .rst_n(rst_n), .cen(cen), .wr(wr), .addr(addr),
        .bw_en(bw_en), .gw(gw), .lane_sel(lane_sel), .wdata(wdata),
        .oe(oe), .desel_single(desel_single), .sleep_req(sleep_req),
        .rdata(rdata), .rdata_drv(rdata_drv), .wr_drop_err(wr_drop_err)
    );

    task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present one command and let one rising edge pass; returns at the falling edge.
    task automatic step(logic c, logic w, logic [AW-1:0] a, logic b, logic g,
                        logic [LN-1:0] s, logic [DW-1:0] d);
        cen = c; wr = w; addr = a; bw_en = b; gw = g; lane_sel = s; wdata = d;
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic rd(logic [AW-1:0] a);
        step(1'b1, 1'b0, a, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic gwrite(logic [AW-1:0] a, logic [DW-1:0] d);
        step(1'b1, 1'b1, a, 1'b0, 1'b1, '0, d);
    endtask

    task automatic rd_check(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
        rd(a);
        rd(a);
        check(req, "read drive", DW'(rdata_drv), DW'(1));
        check(req, "read data", rdata, exp);
        idle();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R10", "drive in reset", DW'(rdata_drv), DW'(0));
        check("R10", "error in reset", DW'(wr_drop_err), DW'(0));
        rst_n = 1'b1;
        idle();
    endtask

    task automatic t_writes();
        desel_single = 1'b1;
        gwrite(6'd1, 32'h1122_3344);
        rd_check(6'd1, 32'h1122_3344, "R5");
        step(1'b1, 1'b1, 6'd1, 1'b1, 1'b0, 4'b0101, 32'hAABB_CCDD);
        rd_check(6'd1, 32'h11BB_33DD, "R4");
        step(1'b1, 1'b1, 6'd1, 1'b0, 1'b0, 4'b1111, 32'h0000_0000);
        rd_check(6'd1, 32'h11BB_33DD, "R4");
        step(1'b1, 1'b1, 6'd2, 1'b0, 1'b1, 4'b0000, 32'h5566_7788);
        rd_check(6'd2, 32'h5566_7788, "R5");
        gwrite(6'd3, 32'h0303_0303);
        gwrite(6'd4, 32'h0404_0404);
        gwrite(6'd5, 32'h0505_0505);
        gwrite(6'd6, 32'h0606_0606);
        rd(6'd2);
        rd(6'd2);
        check("R1", "pipelined read data", rdata, 32'h5566_7788);
        idle();
    endtask

    task automatic t_single();
        desel_single = 1'b1;
        rd(6'd2);
        idle();
        check("R2", "drive after deselect", DW'(rdata_drv), DW'(0));
        rd(6'd2);
        gwrite(6'd7, 32'h7777_7777);
        check("R2", "drive after write", DW'(rdata_drv), DW'(0));
        idle();
    endtask

    task automatic t_dual();
        desel_single = 1'b0;
        idle();
        rd(6'd2);
        idle();
        check("R3", "drive held one cycle", DW'(rdata_drv), DW'(1));
        check("R3", "data held one cycle", rdata, 32'h5566_7788);
        idle();
        check("R3", "drive off after second edge", DW'(rdata_drv), DW'(0));
    endtask

    task automatic t_oe();
        desel_single = 1'b0;
        rd(6'd1);
        idle();
        oe = 1'b0;
        #1;
        check("R9", "oe low gates drive", DW'(rdata_drv), DW'(0));
        oe = 1'b1;
        #1;
        check("R9", "oe high restores drive", DW'(rdata_drv), DW'(1));
        check("R9", "data unchanged", rdata, 32'h11BB_33DD);
        idle();
    endtask

    task automatic t_sleep();
        desel_single = 1'b0;
        rd(6'd3);
        sleep_req = 1'b1;
        rd(6'd3);
        check("R6", "still awake after one edge", DW'(rdata_drv), DW'(1));
        rd(6'd3);
        check("R6", "drive off when asleep", DW'(rdata_drv), DW'(0));
        for (int i = 0; i < 3; i++) begin
            gwrite(6'd3, 32'hDEAD_BEEF);
            check("R6", "drive off in sleep", DW'(rdata_drv), DW'(0));
            check("R6", "no error in sleep", DW'(wr_drop_err), DW'(0));
        end
        sleep_req = 1'b0;
        idle();
        idle();
        rd_check(6'd3, 32'h0303_0303, "R7");
        repeat (REC) idle();
    endtask

    task automatic t_recovery();
        sleep_req = 1'b1;
        repeat (3) idle();
        sleep_req = 1'b0;
        idle();
        idle();
        gwrite(6'd4, 32'h4444_4444);
        check("R8", "error on first window write", DW'(wr_drop_err), DW'(1));
        idle();
        check("R8", "error is a pulse", DW'(wr_drop_err), DW'(0));
        idle();
        gwrite(6'd5, 32'h5555_5555);
        check("R8", "error on last window write", DW'(wr_drop_err), DW'(1));
        gwrite(6'd6, 32'h6666_6666);
        check("R8", "no error after window", DW'(wr_drop_err), DW'(0));
        idle();
        rd_check(6'd4, 32'h0404_0404, "R8");
        rd_check(6'd5, 32'h0505_0505, "R8");
        rd_check(6'd6, 32'h6666_6666, "R8");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_writes();
        t_single();
        t_dual();
        t_oe();
        t_sleep();
        t_recovery();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule